// File: doc/BRIEF.md
# I2C SCL Timing Divider

This block is the bit-timing engine of an I2C master. It divides the source clock with a two-level prescaler. A step counter runs through a programmable number of source cycles. Each time it wraps, a sample counter advances. When the sample counter completes its own count, one SCL half period has elapsed. A half period therefore lasts step count × sample count source cycles, and the SCL period is twice that.

Two timing words feed it. The standard word holds the step count and the sample count, each stored minus one. The high-speed word holds the same two counts in other fields, with a narrower step range. When the high-speed word is nonzero it takes precedence over the standard word. The selected counts and the gap length are captured when a transaction starts and stay fixed until the next one.

While `xfer_en_i` is held high the block toggles SCL. It emits single-cycle strobes at each SCL edge, at the SDA change point and at the SDA sample point. A gap request inserts an idle stretch with SCL held high between two phases of a transaction. The byte protocol sits outside this block and consumes the strobes.

Top module: `scl_div_top`

## Requirements
- R1: After reset, SCL is high and every strobe output is low.
- R2: With the high-speed word zero, the step count is standard bits 5:0 plus one and the sample count is standard bits 10:8 plus one. Every SCL low and high half period lasts step count × sample count source cycles.
- R3: With the high-speed word nonzero, the sample count is high-speed bits 14:12 plus one and the step count is high-speed bits 10:8 plus one (at most 8). The half period is their product.
- R4: A zero high-speed word selects standard timing, including the minimum case of a one-cycle half period.
- R5: When `xfer_en_i` is sampled high while idle, SCL is low in the next cycle. `scl_fall_o` pulses in the first cycle of every low half and `scl_rise_o` pulses in the first cycle of every high half.
- R6: `sda_chg_o` pulses once per low half, in the cycle whose index is step count − 1, counting the first low cycle as index 0.
- R7: `sda_smp_o` pulses once per high half, in the cycle whose index is floor(half period / 2), counting the first high cycle as index 0.
- R8: Timing words and gap length are captured at transaction start. Changes to them during a transaction do not affect it.
- R9: If `xfer_en_i` is low when a high half ends, the block returns to idle. In idle, SCL stays high and no strobe fires.
- R10: A `gap_req_i` pulse during a transaction makes the block hold SCL high for gap length × half period cycles after the next high half ends, with no strobes, before the next low half. A gap length of zero inserts no gap.
- R11: A `gap_req_i` pulse while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_en_i | input | 1 | Run SCL; high starts a transaction, low ends it after a high half |
| gap_req_i | input | 1 | Request an idle gap after the next high half |
| timing_std_i | input | 16 | Standard timing word (step−1 at 5:0, sample−1 at 10:8) |
| timing_hs_i | input | 16 | High-speed timing word (step−1 at 10:8, sample−1 at 14:12), zero disables it |
| gap_len_i | input | 8 | Gap length in half periods |
| scl_o | output | 1 | SCL level |
| scl_fall_o | output | 1 | First cycle of an SCL low half |
| scl_rise_o | output | 1 | First cycle of an SCL high half |
| sda_chg_o | output | 1 | SDA change point |
| sda_smp_o | output | 1 | SDA sample point |

## Verification
A counter that wraps at the wrong value, or a wrongly decoded field, stretches or shortens the very first low half. This shows up as a misplaced `scl_rise_o` within one half period of the start. A wrong phase or pending-gap state shows up at the end of the next high half, as a missing or extra fall strobe, or as SCL held high for the wrong length. The bench compares every output on every cycle of each transaction against a waveform built from the requirements. Any such fault is therefore reported in the first cycle where it becomes visible.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

    localparam int STEP_W = 6;
    localparam int SAMP_W = 3;
    localparam int HS_STEP_W = 3;
    localparam int REG_W = 16;
    localparam int DLY_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2,
        PH_GAP  = 2'd3
    } phase_e;

    typedef struct packed {
        logic [STEP_W-1:0] step_m1;
        logic [SAMP_W-1:0] samp_m1;
        logic [DLY_W-1:0]  dly;
        logic              hs;
    } cfg_t;

endpackage

// File: rtl/scl_div_cfg_dec.sv
module scl_div_cfg_dec
    import scl_div_pkg::*;
#(
    parameter int P_REG_W = REG_W
) (
    input  logic [P_REG_W-1:0] std_word,
    input  logic [P_REG_W-1:0] hs_word,
    input  logic [DLY_W-1:0]   gap_len,
    output cfg_t               cfg
);
    localparam int STD_STEP_LSB = 0;
    localparam int STD_SAMP_LSB = 8;
    localparam int HS_STEP_LSB  = 8;
    localparam int HS_SAMP_LSB  = 12;

    always_comb begin
        cfg.hs  = |hs_word;
        cfg.dly = gap_len;
        if (cfg.hs) begin
            cfg.step_m1 = STEP_W'(hs_word[HS_STEP_LSB +: HS_STEP_W]);
            cfg.samp_m1 = hs_word[HS_SAMP_LSB +: SAMP_W];
        end else begin
            cfg.step_m1 = std_word[STD_STEP_LSB +: STEP_W];
            cfg.samp_m1 = std_word[STD_SAMP_LSB +: SAMP_W];
        end
    end

endmodule

// File: rtl/scl_div_prescale.sv
module scl_div_prescale
    import scl_div_pkg::*;
#(
    parameter int P_STEP_W = STEP_W,
    parameter int P_SAMP_W = SAMP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic [P_STEP_W-1:0] step_m1,
    input  logic [P_SAMP_W-1:0] samp_m1,
    output logic [P_STEP_W-1:0] step_cnt,
    output logic [P_SAMP_W-1:0] samp_cnt,
    output logic                half_done
);
    typedef struct packed {
        logic [P_STEP_W-1:0] step;
        logic [P_SAMP_W-1:0] samp;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic step_wrap;

    always_comb begin
        step_wrap = (cnt_q.step == step_m1);
        half_done = step_wrap && (cnt_q.samp == samp_m1);
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (step_wrap) begin
            cnt_d.step = '0;
            cnt_d.samp = (cnt_q.samp == samp_m1) ? '0 : cnt_q.samp + 1'b1;
        end else begin
            cnt_d.step = cnt_q.step + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign step_cnt = cnt_q.step;
    assign samp_cnt = cnt_q.samp;

endmodule

// File: rtl/scl_div_strobe.sv
module scl_div_strobe
    import scl_div_pkg::*;
(
    input  phase_e            phase,
    input  cfg_t              cfg,
    input  logic [STEP_W-1:0] step_cnt,
    input  logic [SAMP_W-1:0] samp_cnt,
    output logic              sda_chg,
    output logic              sda_smp
);
    localparam int CNT_W = STEP_W + SAMP_W + 1;

    logic [CNT_W-1:0] step_len;
    logic [CNT_W-1:0] half_len;
    logic [CNT_W-1:0] mid_idx;
    logic [CNT_W-1:0] cur_idx;

    always_comb begin
        step_len = CNT_W'(cfg.step_m1) + 1'b1;
        half_len = (CNT_W'(cfg.samp_m1) + 1'b1) * step_len;
        mid_idx  = half_len >> 1;
        cur_idx  = CNT_W'(samp_cnt) * step_len + CNT_W'(step_cnt);
        sda_chg  = (phase == PH_LOW) && (samp_cnt == '0) && (step_cnt == cfg.step_m1);
        sda_smp  = (phase == PH_HIGH) && (cur_idx == mid_idx);
    end

endmodule

// File: rtl/scl_div_top.sv
module scl_div_top
    import scl_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_en_i,
    input  logic             gap_req_i,
    input  logic [REG_W-1:0] timing_std_i,
    input  logic [REG_W-1:0] timing_hs_i,
    input  logic [DLY_W-1:0] gap_len_i,
    output logic             scl_o,
    output logic             scl_fall_o,
    output logic             scl_rise_o,
    output logic             sda_chg_o,
    output logic             sda_smp_o
);
    typedef struct packed {
        phase_e            phase;
        logic              scl;
        logic              fall;
        logic              rise;
        logic              pend;
        logic [DLY_W-1:0]  gap_cnt;
        cfg_t              cfg;
    } st_t;

    st_t st_d, st_q;
    cfg_t cfg_new;
    logic [STEP_W-1:0] step_cnt;
    logic [SAMP_W-1:0] samp_cnt;
    logic half_done;
    logic busy;

    scl_div_cfg_dec #(.P_REG_W(REG_W)) u_dec (
        .std_word (timing_std_i),
        .hs_word  (timing_hs_i),
        .gap_len  (gap_len_i),
        .cfg      (cfg_new)
    );

    scl_div_prescale #(.P_STEP_W(STEP_W), .P_SAMP_W(SAMP_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (st_q.phase == PH_IDLE),
        .step_m1   (st_q.cfg.step_m1),
        .samp_m1   (st_q.cfg.samp_m1),
        .step_cnt  (step_cnt),
        .samp_cnt  (samp_cnt),
        .half_done (half_done)
    );

    scl_div_strobe u_stb (
        .phase    (st_q.phase),
        .cfg      (st_q.cfg),
        .step_cnt (step_cnt),
        .samp_cnt (samp_cnt),
        .sda_chg  (sda_chg_o),
        .sda_smp  (sda_smp_o)
    );

    always_comb begin
        st_d = st_q;
        st_d.fall = 1'b0;
        st_d.rise = 1'b0;
        if (gap_req_i && st_q.phase != PH_IDLE) st_d.pend = 1'b1;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (xfer_en_i) begin
                    st_d.phase   = PH_LOW;
                    st_d.scl     = 1'b0;
                    st_d.fall    = 1'b1;
                    st_d.pend    = 1'b0;
                    st_d.gap_cnt = '0;
                    st_d.cfg     = cfg_new;
                end
            end
            PH_LOW: begin
                if (half_done) begin
                    st_d.phase = PH_HIGH;
                    st_d.scl   = 1'b1;
                    st_d.rise  = 1'b1;
                end
            end
            PH_HIGH: begin
                if (half_done) begin
                    if (st_q.pend && st_q.cfg.dly != '0) begin
                        st_d.phase   = PH_GAP;
                        st_d.pend    = 1'b0;
                        st_d.gap_cnt = '0;
                    end else begin
                        if (st_q.pend) st_d.pend = 1'b0;
                        if (xfer_en_i) begin
                            st_d.phase = PH_LOW;
                            st_d.scl   = 1'b0;
                            st_d.fall  = 1'b1;
                        end else begin
                            st_d.phase = PH_IDLE;
                        end
                    end
                end
            end
            PH_GAP: begin
                if (half_done) begin
                    if (st_q.gap_cnt == st_q.cfg.dly - 1'b1) begin
                        if (xfer_en_i) begin
                            st_d.phase = PH_LOW;
                            st_d.scl   = 1'b0;
                            st_d.fall  = 1'b1;
                        end else begin
                            st_d.phase = PH_IDLE;
                        end
                    end else begin
                        st_d.gap_cnt = st_q.gap_cnt + 1'b1;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.scl   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy       = (st_q.phase != PH_IDLE);
    assign scl_o      = st_q.scl;
    assign scl_fall_o = st_q.fall;
    assign scl_rise_o = st_q.rise;

endmodule

// File: rtl/scl_div_chk.sv
module scl_div_chk
    import scl_div_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl,
    input logic              fall,
    input logic              rise,
    input logic              chg,
    input logic              smp,
    input logic              busy,
    input cfg_t              cfg,
    input logic [STEP_W-1:0] step_cnt
);
    // R5
    fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl) |-> fall);
    // R5
    rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl) |-> rise);
    // R5
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fall, rise}));
    // R6
    chg_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg |-> !scl);
    // R7
    smp_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp |-> scl);
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (scl && !chg && !smp && !rise));
    // R2
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_cnt <= cfg.step_m1);
    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cfg));

endmodule

bind scl_div_top scl_div_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl      (scl_o),
    .fall     (scl_fall_o),
    .rise     (scl_rise_o),
    .chg      (sda_chg_o),
    .smp      (sda_smp_o),
    .busy     (busy),
    .cfg      (st_q.cfg),
    .step_cnt (step_cnt)
);

// File: tb/scl_div_top_tb_top.sv
`timescale 1ns/1ps
module scl_div_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_en = 1'b0;
    logic        gap_req = 1'b0;
    logic [15:0] std_w = '0;
    logic [15:0] hs_w = '0;
    logic [7:0]  dly_w = '0;
    logic        scl, fall, rise, chg, smp;

    int n_vec = 0;
    int n_bad = 0;

    typedef struct {
        logic [4:0] v;
        string      req;
    } item_t;

    item_t exp_q[$];

    always #2 clk = ~clk;

    scl_div_top dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .xfer_en_i    (xfer_en),
        .gap_req_i    (gap_req),
        .timing_std_i (std_w),
        .timing_hs_i  (hs_w),
        .gap_len_i    (dly_w),
        .scl_o        (scl),
        .scl_fall_o   (fall),
        .scl_rise_o   (rise),
        .sda_chg_o    (chg),
        .sda_smp_o    (smp)
    );

    function automatic void push(input logic [4:0] v, input string req);
        item_t it;
        it.v = v;
        it.req = req;
        exp_q.push_back(it);
    endfunction

    task automatic compare(input logic [4:0] exp_v, input string req);
        logic [4:0] got;
        got = {scl, fall, rise, chg, smp};
        n_vec++;
        if (got !== exp_v) begin
            n_bad++;
            $display("FAIL %s: scl/fall/rise/chg/smp got %b expected %b at %0t",
                     req, got, exp_v, $time);
        end
    endtask

    // monitor: pops one expected vector per cycle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                compare(it.v, it.req);
            end
        end
    end

    // driver: builds the expected waveform and drives one transaction
    task automatic run_xfer(input string tag, input logic [15:0] sv, input logic [15:0] hv,
                            input logic [7:0] dv, input int pairs, input int gap_pair,
                            input bit idle_req, input bit change_mid);
        int s, p, n, c, last_high_c, gap_c;
        if (hv != 16'h0) begin
            s = int'(hv[14:12]) + 1;
            p = int'(hv[10:8]) + 1;
        end else begin
            s = int'(sv[10:8]) + 1;
            p = int'(sv[5:0]) + 1;
        end
        n = s * p;
        @(negedge clk);
        std_w = sv; hs_w = hv; dly_w = dv;
        xfer_en = 1'b1;
        gap_req = idle_req;
        c = 0; last_high_c = 0; gap_c = -1;
        for (int k = 0; k < pairs; k++) begin
            if (k == gap_pair) gap_c = c;
            for (int i = 0; i < n; i++) begin
                push({1'b0, i == 0, 1'b0, i == p - 1, 1'b0},
                     {tag, (i == 0) ? " R5 fall" : " R6 low phase"});
                c++;
            end
            if (k == pairs - 1) last_high_c = c;
            for (int i = 0; i < n; i++) begin
                push({1'b1, 1'b0, i == 0, 1'b0, i == n / 2},
                     {tag, (i == 0) ? " R5 rise" : " R7 high phase"});
                c++;
            end
            if (k == gap_pair && dv != 8'd0) begin
                for (int i = 0; i < int'(dv) * n; i++) begin
                    push(5'b10000, {tag, " R10 gap"});
                    c++;
                end
            end
        end
        push(5'b10000, {tag, " R9 idle"});
        push(5'b10000, {tag, " R9 idle"});
        for (int cy = 0; cy < c; cy++) begin
            @(negedge clk);
            gap_req = (cy == gap_c);
            if (change_mid && cy == 1) begin
                std_w = 16'h0000;
                hs_w  = 16'h7703;
                dly_w = 8'd0;
            end
            if (cy == last_high_c) xfer_en = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(5'b10000, "R1 reset value");
        rst_n = 1'b1;
        @(negedge clk);
        compare(5'b10000, "R1 after reset release");
        // R2: standard word, step 4, sample 2 -> 8-cycle halves
        run_xfer("R2", 16'h0103, 16'h0000, 8'd2, 2, -1, 1'b0, 1'b0);
        // R3: high-speed word wins, sample 3, step 2 -> 6-cycle halves
        run_xfer("R3", 16'h050A, 16'h2103, 8'd2, 2, -1, 1'b0, 1'b0);
        // R4: zero high-speed word, minimum one-cycle halves
        run_xfer("R4", 16'h0000, 16'h0000, 8'd2, 2, -1, 1'b0, 1'b0);
        // R8: words changed mid-transaction must not matter
        run_xfer("R8", 16'h0302, 16'h0000, 8'd2, 2, -1, 1'b0, 1'b1);
        // R10: gap of 2 halves after the first pair
        run_xfer("R10", 16'h0201, 16'h0000, 8'd2, 3, 0, 1'b0, 1'b0);
        // R10: gap length zero inserts nothing
        run_xfer("R10", 16'h0201, 16'h0000, 8'd0, 2, 0, 1'b0, 1'b0);
        // R11: gap request while idle ignored
        run_xfer("R11", 16'h0101, 16'h0000, 8'd3, 2, -1, 1'b1, 1'b0);
        // R3: largest high-speed setting, 64-cycle halves
        run_xfer("R3", 16'h0000, 16'h7703, 8'd2, 1, -1, 1'b0, 1'b0);
        // R2: largest standard setting, 512-cycle halves
        run_xfer("R2", 16'h073F, 16'h0000, 8'd2, 1, -1, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        compare(5'b10000, "R9 final idle");
        finish_run();
    end

endmodule